// File: doc/BRIEF.md
# Masked Packed Float Widening Converter

This block widens a vector of IEEE-754 single-precision values into a vector of double-precision values and writes the result into a 512-bit destination register. Each active result lane takes the 32-bit element at the same index, or element 0 when broadcast is chosen, and turns it into an exact 64-bit value. Denormal inputs are normalized. Signaling NaNs are made quiet and raise an invalid flag.

A per-lane write mask selects which active lanes are converted. In merging mode an unselected lane keeps its old destination value, and in zeroing mode it is cleared. The vector-length select sets how many lanes are active. In normal mode every destination bit above the active length is cleared. Legacy mode always converts exactly two lanes and leaves bits 511:128 as they were. A caller presents one operation per `in_valid` cycle, and the result and flags appear in the register one clock later.

Top module: `fpw_widen`

## Requirements
- R1: The active lane count is 2 when `vlen_sel` is 0, 4 when it is 1, and 8 when it is 2 or 3. Result lane j sits in `dest_out[64j+63:64j]` and is taken from `src_vec[32j+31:32j]`. The result is visible on the clock edge after an `in_valid` cycle.
- R2: A normal input keeps its sign, its exponent is rebiased by adding 896, and its 23-bit fraction becomes fraction bits 51:29 with zeros below. A zero input gives a zero of the same sign. An infinity gives an infinity of the same sign.
- R3: A denormal input (exponent 0, fraction not 0) is normalized to a double. Its exponent is 896 minus the number of leading zeros in the 23-bit fraction. The input also sets `flag_den`.
- R4: A NaN input gives exponent 2047 and keeps its payload, with fraction bit 51 forced to 1. The input sets `flag_inv` only when its fraction bit 22 was 0, which marks a signaling NaN.
- R5: With `mask_en`=1 and `zero_mode`=0, an active lane whose mask bit is 0 keeps its previous destination value.
- R6: With `mask_en`=1 and `zero_mode`=1, an active lane whose mask bit is 0 is written with 0.
- R7: With `mask_en`=0, every active lane is converted whatever the value of `mask_bits`.
- R8: With `bcast`=1 outside legacy mode, every converted lane uses `src_vec[31:0]`.
- R9: Outside legacy mode, every destination bit from the active length up to bit 511 is written with 0.
- R10: With `legacy_mode`=1, lanes 0 and 1 are converted unconditionally, bits 511:128 are unchanged, and `vlen_sel`, `mask_en`, `mask_bits`, `zero_mode` and `bcast` have no effect.
- R11: `flag_inv` and `flag_den` are the OR over converted lanes only, and are registered together with the result.
- R12: Synchronous reset clears the destination and both flags. While `in_valid` is 0, the destination and both flags hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Perform one conversion this cycle |
| src_vec | input | 256 | Packed single-precision source elements |
| vlen_sel | input | 2 | Result length: 0=128, 1=256, 2/3=512 bits |
| mask_en | input | 1 | Apply the lane mask |
| mask_bits | input | 8 | Per-lane write enable, bit j for lane j |
| zero_mode | input | 1 | 1 = clear unselected lanes, 0 = keep them |
| bcast | input | 1 | Use element 0 for every lane |
| legacy_mode | input | 1 | Two lanes, preserve bits 511:128 |
| dest_out | output | 512 | Destination register |
| flag_inv | output | 1 | A converted lane held a signaling NaN |
| flag_den | output | 1 | A converted lane held a denormal |

## Verification
The destination register feeds back into its own next value, through merging and through legacy preservation. A wrong lane decision therefore leaves a bad value that persists and shows up one clock after the faulty operation. It stays visible until a later operation overwrites that lane. The reference model tracks the full 512-bit destination across operations, so a stale or wrongly cleared lane is reported at the first compare after that cycle. A wrong flag is reported at that same compare. Because each operation replaces both flags, a flag that stays stuck is caught on the next operation that should clear it.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

    localparam int SP_W   = 32;
    localparam int DP_W   = 64;
    localparam int SP_FW  = 23;
    localparam int DP_FW  = 52;
    localparam int PAD_W  = DP_FW - SP_FW;
    localparam logic [10:0] REBIAS = 11'd896;

    typedef struct packed {
        logic [DP_W-1:0] val;
        logic            inv;
        logic            den;
    } wide_res_t;

    typedef enum logic [1:0] {
        LANE_CONVERT = 2'd0,
        LANE_KEEP    = 2'd1,
        LANE_CLEAR   = 2'd2
    } lane_act_t;

    // Position of the highest set bit, counted as zeros from the top
    function automatic logic [4:0] lead_zeros23(input logic [SP_FW-1:0] f);
        logic [4:0] lz;
        lz = 5'd0;
        for (int i = 0; i < SP_FW; i++) begin
            if (f[i]) lz = 5'(SP_FW - 1 - i);
        end
        return lz;
    endfunction

endpackage

// File: rtl/fpw_lane_cvt.sv
module fpw_lane_cvt
    import fpw_pkg::*;
(
    input  logic [SP_W-1:0] sp_in,
    output wide_res_t       res
);
    logic             sgn;
    logic [7:0]       exp_s;
    logic [SP_FW-1:0] frac_s;
    logic [4:0]       lz;
    logic [SP_FW-1:0] norm_frac;

    assign sgn    = sp_in[31];
    assign exp_s  = sp_in[30:23];
    assign frac_s = sp_in[22:0];
    assign lz     = lead_zeros23(frac_s);
    assign norm_frac = frac_s << (lz + 5'd1);

    always_comb begin
        res = '0;
        if (exp_s == 8'h00) begin
            if (frac_s == '0) begin
                res.val = {sgn, 63'd0};
            end else begin
                res.val = {sgn, REBIAS - {6'd0, lz}, norm_frac, {PAD_W{1'b0}}};
                res.den = 1'b1;
            end
        end else if (exp_s == 8'hFF) begin
            if (frac_s == '0) begin
                res.val = {sgn, 11'h7FF, {DP_FW{1'b0}}};
            end else begin
                res.val = {sgn, 11'h7FF, 1'b1, frac_s[21:0], {PAD_W{1'b0}}};
                res.inv = ~frac_s[22];
            end
        end else begin
            res.val = {sgn, {3'd0, exp_s} + REBIAS, frac_s, {PAD_W{1'b0}}};
        end
    end
endmodule

// File: rtl/fpw_lane_ctl.sv
module fpw_lane_ctl
    import fpw_pkg::*;
#(
    parameter int IDX = 0,
    parameter int CW  = 4
) (
    input  logic [CW-1:0] active_cnt,
    input  logic          legacy_mode,
    input  logic          mask_en,
    input  logic          mask_bit,
    input  logic          zero_mode,
    output lane_act_t     act
);
    localparam logic [CW-1:0] IDX_C = CW'(IDX);

    logic active;
    assign active = IDX_C < active_cnt;

    always_comb begin
        if (legacy_mode) begin
            act = active ? LANE_CONVERT : LANE_KEEP;
        end else if (!active) begin
            act = LANE_CLEAR;
        end else if (!mask_en || mask_bit) begin
            act = LANE_CONVERT;
        end else begin
            act = zero_mode ? LANE_CLEAR : LANE_KEEP;
        end
    end
endmodule

// File: rtl/fpw_widen.sv
module fpw_widen
    import fpw_pkg::*;
#(
    parameter int LANES     = 8,
    parameter int LEG_LANES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [LANES*SP_W-1:0] src_vec,
    input  logic [1:0]            vlen_sel,
    input  logic                  mask_en,
    input  logic [LANES-1:0]      mask_bits,
    input  logic                  zero_mode,
    input  logic                  bcast,
    input  logic                  legacy_mode,
    output logic [LANES*DP_W-1:0] dest_out,
    output logic                  flag_inv,
    output logic                  flag_den
);
    localparam int CW = $clog2(LANES + 1);

    logic [CW-1:0]               active_cnt;
    logic [CW-1:0]               req_cnt;
    logic [LANES-1:0][DP_W-1:0]  dest_q;
    logic [LANES-1:0][DP_W-1:0]  nxt_lane;
    logic [LANES-1:0]            inv_v;
    logic [LANES-1:0]            den_v;

    always_comb begin
        if (legacy_mode) begin
            req_cnt = CW'(LEG_LANES);
        end else begin
            case (vlen_sel)
                2'd0:    req_cnt = CW'(2);
                2'd1:    req_cnt = CW'(4);
                default: req_cnt = CW'(8);
            endcase
        end
        active_cnt = (req_cnt > CW'(LANES)) ? CW'(LANES) : req_cnt;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [SP_W-1:0] elem;
        wide_res_t       res;
        lane_act_t       act;

        assign elem = (bcast && !legacy_mode) ? src_vec[SP_W-1:0]
                                              : src_vec[SP_W*j +: SP_W];

        fpw_lane_cvt u_cvt (
            .sp_in (elem),
            .res   (res)
        );

        fpw_lane_ctl #(.IDX(j), .CW(CW)) u_ctl (
            .active_cnt  (active_cnt),
            .legacy_mode (legacy_mode),
            .mask_en     (mask_en),
            .mask_bit    (mask_bits[j]),
            .zero_mode   (zero_mode),
            .act         (act)
        );

        always_comb begin
            case (act)
                LANE_CONVERT: nxt_lane[j] = res.val;
                LANE_KEEP:    nxt_lane[j] = dest_q[j];
                default:      nxt_lane[j] = '0;
            endcase
        end

        assign inv_v[j] = (act == LANE_CONVERT) && res.inv;
        assign den_v[j] = (act == LANE_CONVERT) && res.den;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dest_q   <= '0;
            flag_inv <= 1'b0;
            flag_den <= 1'b0;
        end else if (in_valid) begin
            dest_q   <= nxt_lane;
            flag_inv <= |inv_v;
            flag_den <= |den_v;
        end
    end

    assign dest_out = dest_q;
endmodule

// File: rtl/fpw_widen_chk.sv
module fpw_widen_chk #(
    parameter int LANES = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [LANES*32-1:0] src_vec,
    input logic [1:0]          vlen_sel,
    input logic                mask_en,
    input logic [LANES-1:0]    mask_bits,
    input logic                zero_mode,
    input logic                bcast,
    input logic                legacy_mode,
    input logic [LANES*64-1:0] dest_out,
    input logic                flag_inv,
    input logic                flag_den
);
    localparam int DW = LANES * 64;

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(dest_out) && $stable(flag_inv) && $stable(flag_den)));

    p_upper_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legacy_mode && vlen_sel == 2'd0) |=> (dest_out[DW-1:128] == '0));

    p_legacy_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && legacy_mode) |=> $stable(dest_out[DW-1:128]));

    p_merge_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legacy_mode && mask_en && !zero_mode && !mask_bits[1])
        |=> $stable(dest_out[127:64]));

    p_zero_lane_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legacy_mode && mask_en && zero_mode && !mask_bits[0])
        |=> (dest_out[63:0] == 64'd0));

    p_no_conv_flags_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legacy_mode && mask_en && mask_bits == '0)
        |=> (!flag_inv && !flag_den));

    p_denorm_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legacy_mode && !mask_en && !bcast && src_vec[30:23] == 8'd0
         && src_vec[22:0] != 23'd0) |=> flag_den);

    p_snan_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && legacy_mode && src_vec[30:22] == 9'h1FE && src_vec[21:0] != 22'd0)
        |=> flag_inv);
endmodule

bind fpw_widen fpw_widen_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .src_vec     (src_vec),
    .vlen_sel    (vlen_sel),
    .mask_en     (mask_en),
    .mask_bits   (mask_bits),
    .zero_mode   (zero_mode),
    .bcast       (bcast),
    .legacy_mode (legacy_mode),
    .dest_out    (dest_out),
    .flag_inv    (flag_inv),
    .flag_den    (flag_den)
);

// File: tb/fpw_widen_tb.sv
`timescale 1ns/1ps
module fpw_widen_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [255:0] src_vec;
    logic [1:0]   vlen_sel;
    logic         mask_en;
    logic [7:0]   mask_bits;
    logic         zero_mode;
    logic         bcast;
    logic         legacy_mode;
    logic [511:0] dest_out;
    logic         flag_inv;
    logic         flag_den;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [511:0] m_dest;
    bit           m_inv;
    bit           m_den;

    always #10 clk = ~clk;

    fpw_widen u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
        .vlen_sel(vlen_sel), .mask_en(mask_en), .mask_bits(mask_bits),
        .zero_mode(zero_mode), .bcast(bcast), .legacy_mode(legacy_mode),
        .dest_out(dest_out), .flag_inv(flag_inv), .flag_den(flag_den)
    );

    // Behavioural single-to-double widening: shift-until-normal loop
    function automatic logic [63:0] ref_w(input logic [31:0] x, output bit inv, output bit den);
        int          e;
        int          ee;
        logic [51:0] m;
        inv = 0;
        den = 0;
        e = int'(x[30:23]);
        m = {x[22:0], 29'd0};
        if (e == 255) begin
            if (m != 0) begin
                inv = !x[22];
                m[51] = 1'b1;
            end
            return {x[31], 11'h7FF, m};
        end
        if (e == 0) begin
            if (m == 0) return {x[31], 63'd0};
            den = 1;
            ee = 897;
            while (!m[51]) begin
                m = m << 1;
                ee = ee - 1;
            end
            m = m << 1;
            ee = ee - 1;
            return {x[31], ee[10:0], m};
        end
        ee = e + 896;
        return {x[31], ee[10:0], m};
    endfunction

    task automatic model_step();
        int  nl;
        bit  li, ld;
        logic [511:0] nd;
        logic [31:0]  el;
        logic [63:0]  wv;
        bit  fi, fd;
        fi = 0;
        fd = 0;
        nd = m_dest;
        if (legacy_mode) begin
            for (int j = 0; j < 2; j++) begin
                wv = ref_w(src_vec[32*j +: 32], li, ld);
                nd[64*j +: 64] = wv;
                fi |= li;
                fd |= ld;
            end
        end else begin
            nl = (vlen_sel == 0) ? 2 : (vlen_sel == 1) ? 4 : 8;
            for (int j = 0; j < 8; j++) begin
                if (j >= nl) begin
                    nd[64*j +: 64] = '0;
                end else if (!mask_en || mask_bits[j]) begin
                    el = bcast ? src_vec[31:0] : src_vec[32*j +: 32];
                    wv = ref_w(el, li, ld);
                    nd[64*j +: 64] = wv;
                    fi |= li;
                    fd |= ld;
                end else if (zero_mode) begin
                    nd[64*j +: 64] = '0;
                end
            end
        end
        m_dest = nd;
        m_inv  = fi;
        m_den  = fd;
    endtask

    task automatic check_state(input string tag);
        n_run++;
        if (dest_out !== m_dest || flag_inv !== m_inv || flag_den !== m_den) begin
            n_fail++;
            $display("FAIL %s dest=%h inv=%0b den=%0b expected dest=%h inv=%0b den=%0b",
                     tag, dest_out, flag_inv, flag_den, m_dest, m_inv, m_den);
        end
    endtask

    task automatic check_lane(input string tag, input int j, input logic [63:0] exp_v);
        n_run++;
        if (dest_out[64*j +: 64] !== exp_v) begin
            n_fail++;
            $display("FAIL %s lane%0d actual=%h expected=%h", tag, j, dest_out[64*j +: 64], exp_v);
        end
    endtask

    // Called at a negedge: drive, clock, compare at the following negedge
    task automatic op(input string tag, input logic v, input logic [255:0] s, input logic [1:0] vl,
                      input logic me, input logic [7:0] mb, input logic zm, input logic bc,
                      input logic lg);
        in_valid = v; src_vec = s; vlen_sel = vl; mask_en = me; mask_bits = mb;
        zero_mode = zm; bcast = bc; legacy_mode = lg;
        if (v) model_step();
        @(posedge clk);
        @(negedge clk);
        check_state(tag);
    endtask

    function automatic logic [31:0] rand_sp();
        logic [31:0] r;
        r = $urandom;
        case ($urandom % 6)
            0: r[30:23] = 8'h00;
            1: r[30:0]  = 31'd0;
            2: r[30:0]  = {8'hFF, 23'd0};
            3: begin r[30:23] = 8'hFF; r[22] = 1'b1; end
            4: begin r[30:22] = 9'h1FE; r[0] = 1'b1; end
            default: ;
        endcase
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [255:0] s;
        rst = 1; in_valid = 0; src_vec = '0; vlen_sel = 0; mask_en = 0; mask_bits = 0;
        zero_mode = 0; bcast = 0; legacy_mode = 0;
        m_dest = '0; m_inv = 0; m_den = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_state("R12 reset");

        // Fill with garbage so later clears are visible
        for (int j = 0; j < 8; j++) s[32*j +: 32] = 32'h40000000 + 32'(j);
        op("R1 fill512", 1, s, 2'd3, 0, 8'h00, 0, 0, 0);

        s = '0;
        s[31:0] = 32'h3F800000; s[63:32] = 32'hC0200000;
        op("R9 len128", 1, s, 2'd0, 0, 8'h00, 0, 0, 0);
        check_lane("R2 one", 0, 64'h3FF0000000000000);
        check_lane("R2 neg2p5", 1, 64'hC004000000000000);

        s = '0;
        s[31:0] = 32'h80000000; s[63:32] = 32'h7F800000; s[95:64] = 32'hFF800000; s[127:96] = 32'h3EAAAAAB;
        op("R1 len256", 1, s, 2'd1, 0, 8'h00, 0, 0, 0);
        check_lane("R2 negzero", 0, 64'h8000000000000000);
        check_lane("R2 inf", 1, 64'h7FF0000000000000);

        s = '0;
        s[31:0] = 32'h00000001; s[63:32] = 32'h80400000;
        op("R3 denorm", 1, s, 2'd0, 0, 8'h00, 0, 0, 0);
        check_lane("R3 min", 0, 64'h36A0000000000000);
        check_lane("R3 half", 1, 64'hB800000000000000);

        s = '0;
        s[31:0] = 32'h7F800001; s[63:32] = 32'hFFC12345;
        op("R4 nan", 1, s, 2'd0, 0, 8'h00, 0, 0, 0);
        check_lane("R4 snan", 0, 64'h7FF8000020000000);
        s[31:0] = 32'h3F800000;
        op("R4 qnan noflag", 1, s, 2'd0, 0, 8'h00, 0, 0, 0);

        for (int j = 0; j < 8; j++) s[32*j +: 32] = 32'h3F800000 + (32'(j) << 20);
        op("R7 nomask", 1, s, 2'd2, 0, 8'h00, 0, 0, 0);
        for (int j = 0; j < 8; j++) s[32*j +: 32] = 32'hC1000000 + (32'(j) << 18);
        op("R5 merge", 1, s, 2'd2, 1, 8'hA5, 0, 0, 0);
        op("R6 zero", 1, s, 2'd2, 1, 8'h3C, 1, 0, 0);
        s[31:0] = 32'h00000010;
        op("R11 masked denorm", 1, s, 2'd2, 1, 8'hFE, 1, 0, 0);
        op("R8 bcast", 1, s, 2'd1, 0, 8'h00, 0, 1, 0);
        check_lane("R8 lane3", 3, dest_out[63:0]);

        op("R1 refill", 1, {8{32'h40490FDB}}, 2'd2, 0, 8'h00, 0, 0, 0);
        op("R10 legacy", 1, {{6{32'h7F800001}}, 32'h00000003, 32'h3F000000}, 2'd2, 1, 8'h00, 1, 1, 1);
        op("R12 idle", 0, '1, 2'd0, 1, 8'h00, 1, 0, 0);

        for (int t = 0; t < 400; t++) begin
            for (int j = 0; j < 8; j++) s[32*j +: 32] = rand_sp();
            op("R11 random", ($urandom % 5) != 0, s, 2'($urandom), 1'($urandom), 8'($urandom),
               1'($urandom), 1'(($urandom % 4) == 0), 1'(($urandom % 5) == 0));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule